// File: doc/BRIEF.md
# Fully Associative Translation Cache with Permission Checks

This block keeps a small set of recently used page table entries so that most memory accesses can be translated without walking the page tables. Every entry is tagged with a virtual page number and a process identifier, and all valid entries are compared with a lookup at the same time. A lookup supplies the virtual page, the current process, the kind of access (read, write or instruction fetch) and whether the requester runs in user mode. One cycle later the block answers with hit or miss, a protection-fault flag, the physical page base and the cache-disable attribute of the matching page.

On a miss the block raises a refill request that carries the missing page and process, so that an external page walker can fetch the entry. The walker then presents a fill. The block picks the slot to overwrite using a not-recently-used policy built on a per-entry accessed flag, and it prefers clean pages over modified ones. Hits keep the accessed and modified flags up to date. Two flush controls drop either every entry or only the entries of one process.

Top module: `xlat_cache`

## Requirements
- R1: Every valid entry is compared with a lookup in parallel and a page may be placed in any slot. The entry count is a parameter between 32 and 256. A lookup presented with `lk_valid` high gets its answer on the outputs in the following cycle with `rsp_valid` high; `rsp_valid` is low in every other cycle and after reset.
- R2: A hit needs a valid entry whose stored page and process both equal the lookup's. The hit returns that entry's physical page on `rsp_ppn`. The same page under a different process misses.
- R3: When nothing matches, the answer has `rsp_miss` and `refill_req` high, `rsp_hit` and `rsp_fault` low, `rsp_ppn` zero and `rsp_nocache` low. `refill_vpn` and `refill_pid` repeat the lookup's page and process.
- R4: Access kind is encoded on `lk_kind` as 2'b00 read, 2'b01 write, 2'b10 instruction fetch, with 2'b11 treated as a read. A write hit on an entry whose writable flag is clear reports `rsp_fault` together with `rsp_hit`.
- R5: A hit with `lk_user` high on an entry whose user-access flag is clear (supervisor only) reports `rsp_fault`.
- R6: A fetch hit on an entry whose execute flag is clear reports `rsp_fault`. A hit that breaks none of the rules of R4 to R6 has `rsp_fault` low.
- R7: Every hit sets the entry's accessed flag. A write hit without a fault sets its modified flag. A fill starts with both flags clear, and clearing the accessed flags leaves the modified flags alone.
- R8: A fill goes to the lowest-index invalid slot. If there is none, it goes to the lowest-index entry with accessed clear and modified clear, and then to the lowest-index entry with accessed clear. When every entry has accessed set, all accessed flags are cleared and slot 0 is overwritten.
- R9: `flush_all` invalidates every entry in one cycle. A fill presented in the same cycle as either flush is dropped.
- R10: `flush_pid_en` invalidates only the entries whose process equals `flush_pid`; entries of other processes keep hitting.
- R11: On a hit, `rsp_nocache` carries the cache-disable flag that the entry received at fill time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_pid | input | PID_W | Process identifier of the lookup |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| lk_user | input | 1 | Requester runs in user mode |
| fill_valid | input | 1 | Write a new entry this cycle |
| fill_vpn | input | VPN_W | Virtual page of the new entry |
| fill_pid | input | PID_W | Process of the new entry |
| fill_ppn | input | PPN_W | Physical page base of the new entry |
| fill_wr | input | 1 | New entry allows writes |
| fill_ex | input | 1 | New entry allows instruction fetch |
| fill_usr | input | 1 | New entry allows user-mode access |
| fill_nc | input | 1 | New entry disables caching |
| flush_all | input | 1 | Invalidate all entries |
| flush_pid_en | input | 1 | Invalidate entries of one process |
| flush_pid | input | PID_W | Process selected by flush_pid_en |
| rsp_valid | output | 1 | Answer to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation not present |
| rsp_fault | output | 1 | Access breaks the page permissions |
| rsp_ppn | output | PPN_W | Physical page base, zero on a miss |
| rsp_nocache | output | 1 | Cache-disable flag of the hit entry |
| refill_req | output | 1 | Page walk requested for the missed page |
| refill_vpn | output | VPN_W | Page to walk |
| refill_pid | output | PID_W | Process of the page to walk |

## Verification
A corrupted tag, process or valid bit shows at the ports one cycle after the next lookup of that page, as a wrong hit or miss or a wrong physical page. Wrong accessed or modified flags have no output of their own. They show up only at a later fill, when the wrong page is evicted, and the next lookup of the evicted page or of the page that should have gone then answers the wrong way. The bench therefore drives eviction sequences whose victim order depends on each flag and checks, page by page, which pages still hit. Permission decoding is swept over every combination of page flags, access kinds and privilege modes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic wr;
      logic ex;
      logic usr;
      logic nc;
   } perm_t;

endpackage

// File: rtl/xlat_prienc.sv
module xlat_prienc #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   // lowest set bit wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int N     = 32,
   parameter int VPN_W = 20,
   parameter int PID_W = 8
) (
   input  logic [N-1:0]     valid,
   input  logic [VPN_W-1:0] tag   [N],
   input  logic [PID_W-1:0] owner [N],
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   input  logic [PID_W-1:0] kill_pid,
   output logic [N-1:0]     hit_vec,
   output logic [N-1:0]     kill_vec
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g]  = valid[g] && (tag[g] == lk_vpn) && (owner[g] == lk_pid);
      assign kill_vec[g] = valid[g] && (owner[g] == kill_pid);
   end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
   import xlat_pkg::*;
(
   input  acc_kind_e kind,
   input  logic      user,
   input  perm_t     perm,
   output logic      fault
);
   logic bad_wr, bad_usr, bad_ex;

   always_comb begin
      bad_wr  = (kind == ACC_WRITE) && !perm.wr;
      bad_usr = user && !perm.usr;
      bad_ex  = (kind == ACC_FETCH) && !perm.ex;
      fault   = bad_wr || bad_usr || bad_ex;
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     valid,
   input  logic [N-1:0]     acc,
   input  logic [N-1:0]     dirty,
   output logic [IDX_W-1:0] vic_idx,
   output logic             all_used
);
   localparam int NCLS = 3;

   logic [N-1:0]     cls_vec   [NCLS];
   logic             cls_found [NCLS];
   logic [IDX_W-1:0] cls_idx   [NCLS];

   // class 0: empty slot, class 1: old and clean, class 2: old and modified
   assign cls_vec[0] = ~valid;
   assign cls_vec[1] = valid & ~acc & ~dirty;
   assign cls_vec[2] = valid & ~acc & dirty;

   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      xlat_prienc #(.N(N), .IDX_W(IDX_W)) u_enc (
         .vec   (cls_vec[k]),
         .found (cls_found[k]),
         .idx   (cls_idx[k])
      );
   end

   always_comb begin
      vic_idx  = '0;
      all_used = 1'b1;
      for (int k = NCLS - 1; k >= 0; k--) begin
         if (cls_found[k]) begin
            vic_idx  = cls_idx[k];
            all_used = 1'b0;
         end
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int PID_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   input  logic [1:0]       lk_kind,
   input  logic             lk_user,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PID_W-1:0] fill_pid,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_wr,
   input  logic             fill_ex,
   input  logic             fill_usr,
   input  logic             fill_nc,
   input  logic             flush_all,
   input  logic             flush_pid_en,
   input  logic [PID_W-1:0] flush_pid,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic             rsp_nocache,
   output logic             refill_req,
   output logic [VPN_W-1:0] refill_vpn,
   output logic [PID_W-1:0] refill_pid
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 32 || ENTRIES > 256) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must lie in 32..256");
   end
   if (VPN_W < 1 || PPN_W < 1 || PID_W < 1) begin : g_bad_width
      $error("xlat_cache: widths must be positive");
   end

   // entry storage
   logic [ENTRIES-1:0] v_q, a_q, d_q;
   logic [ENTRIES-1:0] v_nxt, a_nxt, d_nxt;
   logic [VPN_W-1:0]   tag_q  [ENTRIES];
   logic [PID_W-1:0]   pid_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   perm_t              perm_q [ENTRIES];

   logic [ENTRIES-1:0] hit_vec, kill_vec, set_a, set_d;
   logic               any_hit;
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   vic_idx;
   logic               all_used;
   logic               fault;
   logic               fill_go;
   perm_t              hit_perm;
   acc_kind_e          kind;

   assign kind = acc_kind_e'(lk_kind);

   xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
      .valid    (v_q),
      .tag      (tag_q),
      .owner    (pid_q),
      .lk_vpn   (lk_vpn),
      .lk_pid   (lk_pid),
      .kill_pid (flush_pid),
      .hit_vec  (hit_vec),
      .kill_vec (kill_vec)
   );

   xlat_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
      .vec   (hit_vec),
      .found (any_hit),
      .idx   (hit_idx)
   );

   assign hit_perm = perm_q[hit_idx];

   xlat_perm u_perm (
      .kind  (kind),
      .user  (lk_user),
      .perm  (hit_perm),
      .fault (fault)
   );

   xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .valid    (v_q),
      .acc      (a_q),
      .dirty    (d_q),
      .vic_idx  (vic_idx),
      .all_used (all_used)
   );

   // flag and valid next-state
   always_comb begin
      fill_go = fill_valid && !flush_all && !flush_pid_en;
      set_a   = lk_valid ? hit_vec : '0;
      set_d   = (lk_valid && kind == ACC_WRITE && !fault) ? hit_vec : '0;

      if (flush_all)         v_nxt = '0;
      else if (flush_pid_en) v_nxt = v_q & ~kill_vec;
      else                   v_nxt = v_q;

      a_nxt = a_q | set_a;
      d_nxt = d_q | set_d;

      if (fill_go) begin
         if (all_used) a_nxt = '0;
         v_nxt[vic_idx] = 1'b1;
         a_nxt[vic_idx] = 1'b0;
         d_nxt[vic_idx] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         a_q <= '0;
         d_q <= '0;
      end else begin
         v_q <= v_nxt;
         a_q <= a_nxt;
         d_q <= d_nxt;
      end
   end

   // payload storage, no reset needed: gated by v_q
   always_ff @(posedge clk) begin
      if (fill_go) begin
         tag_q[vic_idx]  <= fill_vpn;
         pid_q[vic_idx]  <= fill_pid;
         ppn_q[vic_idx]  <= fill_ppn;
         perm_q[vic_idx] <= '{wr: fill_wr, ex: fill_ex, usr: fill_usr, nc: fill_nc};
      end
   end

   // registered answer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_miss    <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_ppn     <= '0;
         rsp_nocache <= 1'b0;
         refill_req  <= 1'b0;
         refill_vpn  <= '0;
         refill_pid  <= '0;
      end else begin
         rsp_valid   <= lk_valid;
         rsp_hit     <= lk_valid && any_hit;
         rsp_miss    <= lk_valid && !any_hit;
         rsp_fault   <= lk_valid && any_hit && fault;
         rsp_ppn     <= (lk_valid && any_hit) ? ppn_q[hit_idx] : '0;
         rsp_nocache <= lk_valid && any_hit && hit_perm.nc;
         refill_req  <= lk_valid && !any_hit;
         if (lk_valid) begin
            refill_vpn <= lk_vpn;
            refill_pid <= lk_pid;
         end
      end
   end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int PPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             flush_all,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_miss,
   input logic             rsp_fault,
   input logic [PPN_W-1:0] rsp_ppn,
   input logic             rsp_nocache
);
   a_r1_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   a_r1_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));

   a_r3_miss_payload_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_ppn == '0 && !rsp_nocache && !rsp_fault));

   a_r4_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_hit);

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush_all, 2) && rsp_valid) |-> rsp_miss);
endmodule

bind xlat_cache xlat_cache_chk #(.PPN_W(PPN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .flush_all   (flush_all),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_miss    (rsp_miss),
   .rsp_fault   (rsp_fault),
   .rsp_ppn     (rsp_ppn),
   .rsp_nocache (rsp_nocache)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
   localparam int ENTRIES = 32;
   localparam int VPN_W   = 20;
   localparam int PPN_W   = 20;
   localparam int PID_W   = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [PID_W-1:0] lk_pid = '0;
   logic [1:0]       lk_kind = '0;
   logic             lk_user = 0;
   logic             fill_valid = 0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PID_W-1:0] fill_pid = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic             fill_wr = 0, fill_ex = 0, fill_usr = 0, fill_nc = 0;
   logic             flush_all = 0, flush_pid_en = 0;
   logic [PID_W-1:0] flush_pid = '0;
   logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_nocache, refill_req;
   logic [PPN_W-1:0] rsp_ppn;
   logic [VPN_W-1:0] refill_vpn;
   logic [PID_W-1:0] refill_pid;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) u_xlat_cache (
      .clk, .rst_n, .lk_valid, .lk_vpn, .lk_pid, .lk_kind, .lk_user,
      .fill_valid, .fill_vpn, .fill_pid, .fill_ppn, .fill_wr, .fill_ex, .fill_usr, .fill_nc,
      .flush_all, .flush_pid_en, .flush_pid,
      .rsp_valid, .rsp_hit, .rsp_miss, .rsp_fault, .rsp_ppn, .rsp_nocache,
      .refill_req, .refill_vpn, .refill_pid
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one lookup; outputs sampled at the following negedge
   task automatic lookup(input int vpn, input int pid, input int kind, input bit user);
      @(negedge clk);
      lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_pid = PID_W'(pid);
      lk_kind = 2'(kind); lk_user = user;
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic fill(input int vpn, input int pid, input int ppn,
                       input bit wr, input bit ex, input bit usr, input bit nc);
      @(negedge clk);
      fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_pid = PID_W'(pid); fill_ppn = PPN_W'(ppn);
      fill_wr = wr; fill_ex = ex; fill_usr = usr; fill_nc = nc;
      @(negedge clk);
      fill_valid = 0;
   endtask

   task automatic expect_hit(input string tag, input int vpn, input int pid, input int ppn);
      lookup(vpn, pid, 0, 0);
      chk(tag, rsp_hit, 1);
      chk(tag, rsp_ppn, ppn);
   endtask

   task automatic expect_miss(input string tag, input int vpn, input int pid);
      lookup(vpn, pid, 0, 0);
      chk(tag, rsp_miss, 1);
      chk(tag, rsp_hit, 0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset rsp_valid", rsp_valid, 0);
      chk("R1 reset rsp_hit", rsp_hit, 0);
      chk("R3 reset refill_req", refill_req, 0);
      rst_n = 1;
      @(negedge clk);

      // R3: miss on empty structure
      lookup(20'h12345, 8'h3c, 1, 1);
      chk("R1 rsp_valid after lookup", rsp_valid, 1);
      chk("R3 miss", rsp_miss, 1);
      chk("R3 refill_req", refill_req, 1);
      chk("R3 refill_vpn", refill_vpn, 32'h12345);
      chk("R3 refill_pid", refill_pid, 32'h3c);
      chk("R3 ppn zero", rsp_ppn, 0);
      chk("R3 no fault", rsp_fault, 0);
      @(negedge clk);
      chk("R1 rsp_valid idle", rsp_valid, 0);

      // permission sweep: every flag combination x kind x mode
      for (int c = 0; c < 8; c++)
         fill(32'h100 + c, 7, 32'h5000 + 3 * c, c[0], c[1], c[2], c[0] ^ c[1]);
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 4; k++) begin
            for (int u = 0; u < 2; u++) begin
               bit bwr, bus, bex, expf;
               string tg;
               bwr  = (k == 1) && !c[0];
               bex  = (k == 2) && !c[1];
               bus  = (u == 1) && !c[2];
               expf = bwr || bex || bus;
               tg = bwr ? "R4" : (bus ? "R5" : "R6");
               lookup(32'h100 + c, 7, k, u[0]);
               chk($sformatf("R2 hit c%0d k%0d u%0d", c, k, u), rsp_hit, 1);
               chk($sformatf("R2 ppn c%0d", c), rsp_ppn, 32'h5000 + 3 * c);
               chk($sformatf("%s fault c%0d k%0d u%0d", tg, c, k, u), rsp_fault, expf);
               chk($sformatf("R11 nocache c%0d", c), rsp_nocache, c[0] ^ c[1]);
            end
         end
      end

      // R2: same page, other process misses
      expect_miss("R2 foreign pid", 32'h100, 8);

      // R10: per-process flush
      for (int i = 0; i < 4; i++) fill(32'h200 + i, 9, 32'h6000 + i, 1, 1, 1, 0);
      @(negedge clk);
      flush_pid_en = 1; flush_pid = 8'd7;
      @(negedge clk);
      flush_pid_en = 0;
      for (int c = 0; c < 8; c++) expect_miss("R10 flushed pid", 32'h100 + c, 7);
      for (int i = 0; i < 4; i++) expect_hit("R10 other pid kept", 32'h200 + i, 9, 32'h6000 + i);

      // R8: invalid slot taken before any valid entry
      fill(32'h210, 9, 32'h6100, 1, 1, 1, 0);
      for (int i = 0; i < 4; i++) expect_hit("R8 empty slot first", 32'h200 + i, 9, 32'h6000 + i);
      expect_hit("R8 new entry", 32'h210, 9, 32'h6100);

      // R9: flush_all, with a fill in the same cycle
      @(negedge clk);
      flush_all = 1; fill_valid = 1; fill_vpn = 20'h2ff; fill_pid = 8'd9; fill_ppn = 20'h1;
      @(negedge clk);
      flush_all = 0; fill_valid = 0;
      expect_miss("R9 flush all", 32'h200, 9);
      expect_miss("R9 fill dropped", 32'h2ff, 9);

      // R7/R8: replacement order
      for (int i = 0; i < ENTRIES; i++) fill(32'h300 + i, 1, 32'h700 + i, 1, 1, 1, 0);
      for (int i = 0; i < ENTRIES; i++) expect_hit("R1 any slot", 32'h300 + i, 1, 32'h700 + i);
      lookup(32'h305, 1, 1, 0);
      chk("R7 write hit no fault", rsp_fault, 0);
      fill(32'h400, 1, 32'h800, 1, 1, 1, 0);
      expect_miss("R8 all used evicts slot 0", 32'h300, 1);
      expect_hit("R8 refill in slot 0", 32'h400, 1, 32'h800);
      for (int i = 1; i < ENTRIES; i++)
         if (i != 5 && i != 9) expect_hit("R7 touch", 32'h300 + i, 1, 32'h700 + i);
      fill(32'h401, 1, 32'h801, 1, 1, 1, 0);
      expect_miss("R7 clean old page evicted before dirty", 32'h309, 1);
      expect_hit("R7 new page", 32'h401, 1, 32'h801);
      fill(32'h402, 1, 32'h802, 1, 1, 1, 0);
      expect_miss("R8 dirty old page evicted last", 32'h305, 1);
      expect_hit("R8 new page", 32'h402, 1, 32'h802);
      expect_hit("R7 accessed page kept", 32'h301, 1, 32'h701);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule